// File: doc/BRIEF.md
# Host-Register to AXI4-Lite Master Bridge

This block gives a host that only has a narrow 16-bit register port a way to run single 32-bit reads and writes on an AXI4-Lite master port. The host loads a 32-bit target address and, for writes, a 32-bit data word. Each value is split across a pair of 16-bit registers. The host then writes a 4-bit command code into the control register. The bridge runs exactly one AXI4-Lite transaction with all byte strobes set. When the transaction ends it posts one sticky event: read done, write done, bus error or timeout. Each event stays set until the host writes a one to it.

The bridge has eight 16-bit registers. Three further features sit beside the transfer path:
- Two command variants advance the address by one word after a successful transfer, so the host can walk through a block of registers.
- A cycle counter abandons a transaction that gets no answer.
- An external interrupt line is captured as an extra event.

The host-side `irq` output is high while any event bit that the host has enabled is set. A status flag goes high a fixed number of cycles after reset to show that the bridge is ready.

Top module: `axbr_host_bridge`

## Requirements
- R1: While reset is held, the status word reads 0, the irq output is 0, and the bridge drives no AXI valid or ready signal.
- R2: Status bit 5 (ready) is 0 until INIT_CYC clock edges after reset is released. It is 1 from then on.
- R3: The target address is formed as {word at offset 3, word at offset 2}. The write data is formed as {word at offset 5, word at offset 4}. A write command produces one AW and one W handshake carrying these values with all byte strobes set. A read command produces one AR handshake with the address.
- R4: A command is the control-register write field bits 3:0. 0x8 is write, 0x9 is write then advance, 0xA is read, 0xB is read then advance. Every other code, including 0x0, starts nothing.
- R5: A response of OKAY or EXOKAY sets status bit 15 for a read or bit 14 for a write. The two advancing codes then add 4 to the address registers.
- R6: A response of SLVERR or DECERR sets status bit 12 instead of a completion bit. It leaves the read-data registers and the address unchanged.
- R7: A transaction that is still unanswered TIMEOUT_CYC cycles after acceptance is abandoned. This sets status bit 13 and leaves the address unchanged.
- R8: Status bit 6 (busy) is 1 from command acceptance until the event is posted. A command written while busy is ignored and starts no AXI request.
- R9: A successful read stores the 32-bit read data as {offset 7, offset 6} and sets status bit 7. Reading offset 7 clears bit 7.
- R10: Event bits 15:11 are write-one-to-clear through offset 0. Zeros written there leave them unchanged.
- R11: While the ext_irq input is high, event bit 11 is set.
- R12: Control bits 15:11 are per-event enables and read back at offset 1 (low bits read 0). The irq output is high exactly when some enabled event bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Host register offset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects only) |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from reg_addr |
| ext_irq | input | 1 | External interrupt request captured as an event |
| irq | output | 1 | Interrupt to the host |
| m_awaddr | output | 32 | AXI write address |
| m_awprot | output | 3 | AXI write protection, always 0 |
| m_awvalid | output | 1 | AXI write address valid |
| m_awready | input | 1 | AXI write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | AXI write strobes, all ones |
| m_wvalid | output | 1 | AXI write data valid |
| m_wready | input | 1 | AXI write data ready |
| m_bresp | input | 2 | AXI write response |
| m_bvalid | input | 1 | AXI write response valid |
| m_bready | output | 1 | AXI write response ready |
| m_araddr | output | 32 | AXI read address |
| m_arprot | output | 3 | AXI read protection, always 0 |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_rdata | input | 32 | AXI read data |
| m_rresp | input | 2 | AXI read response |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |

## Verification
The assertions check several properties on every cycle:
- An AXI request or response-ready is only driven while busy is set.
- Addresses hold steady while a request waits.
- No busy period outlasts the timeout window.
- Ready never falls once it has risen.
- A read-done event only follows an R handshake, and an error response never raises read-done.
- irq never rises with all enables clear.

Only the bench scenarios can show the rest:
- The values actually carried across the bus.
- Address advance on success and its absence on error or timeout.
- The retention of read data after a failed read.
- The clearing of the data-available flag by a host read.
- The rejection of a command issued during a stalled transfer.
- The exact clear and mask behaviour of the event bits.

// File: rtl/axbr_pkg.sv
package axbr_pkg;
   localparam int unsigned NUM_REGS = 8;
   localparam int unsigned REG_AW   = $clog2(NUM_REGS);

   // host register offsets
   localparam logic [REG_AW-1:0] OFS_STATUS  = 3'd0;
   localparam logic [REG_AW-1:0] OFS_CTRL    = 3'd1;
   localparam logic [REG_AW-1:0] OFS_ADDR_LO = 3'd2;
   localparam logic [REG_AW-1:0] OFS_ADDR_HI = 3'd3;
   localparam logic [REG_AW-1:0] OFS_WDAT_LO = 3'd4;
   localparam logic [REG_AW-1:0] OFS_WDAT_HI = 3'd5;
   localparam logic [REG_AW-1:0] OFS_RDAT_LO = 3'd6;
   localparam logic [REG_AW-1:0] OFS_RDAT_HI = 3'd7;

   // status / control bit positions
   localparam int unsigned EV_LSB     = 11;
   localparam int unsigned EV_N       = 5;
   localparam int unsigned ST_RDAVAIL = 7;
   localparam int unsigned ST_BUSY    = 6;
   localparam int unsigned ST_READY   = 5;

   // index inside the event vector (bit EV_LSB + index in the status word)
   localparam int unsigned EVI_EXT = 0;
   localparam int unsigned EVI_ERR = 1;
   localparam int unsigned EVI_TMO = 2;
   localparam int unsigned EVI_WR  = 3;
   localparam int unsigned EVI_RD  = 4;

   typedef enum logic [1:0] {RES_OK, RES_ERR, RES_TMO} result_e;

   typedef enum logic [2:0] {
      ENG_IDLE, ENG_WADDR, ENG_WRESP, ENG_RADDR, ENG_RDATA
   } eng_state_e;

   // command codes 0x8..0xB: bit3 set, bit2 clear; bit1 = read, bit0 = advance
   function automatic logic is_xfer_cmd(input logic [3:0] code);
      return code[3:2] == 2'b10;
   endfunction
endpackage

// File: rtl/axbr_cnt.sv
module axbr_cnt #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   generate
      if (LIMIT == 0) begin : g_zero
         logic unused_zero;
         assign unused_zero = ^{clk, rst_n, clear, run};
         assign expired = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] LIM = CW'(LIMIT);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (clear)             cnt_q <= '0;
            else if (run && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
         end

         assign expired = (cnt_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/axbr_engine.sv
module axbr_engine
   import axbr_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned TIMEOUT_CYC = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_rd,
   input  logic [AW-1:0] start_addr,
   input  logic [AW-1:0] start_wdata,
   output logic          busy,
   output logic          done,
   output logic          done_rd,
   output result_e       result,
   output logic [AW-1:0] rdata,
   output logic [AW-1:0] m_awaddr,
   output logic          m_awvalid,
   input  logic          m_awready,
   output logic [AW-1:0] m_wdata,
   output logic          m_wvalid,
   input  logic          m_wready,
   input  logic [1:0]    m_bresp,
   input  logic          m_bvalid,
   output logic          m_bready,
   output logic [AW-1:0] m_araddr,
   output logic          m_arvalid,
   input  logic          m_arready,
   input  logic [AW-1:0] m_rdata,
   input  logic [1:0]    m_rresp,
   input  logic          m_rvalid,
   output logic          m_rready
);
   eng_state_e    state_q;
   logic          aw_done_q, w_done_q, rd_q;
   logic [AW-1:0] addr_q, wdata_q;
   logic          tmo_hit, aw_hs, w_hs, ar_hs;
   logic          aw_all, w_all;
   logic          unused_resp;

   assign unused_resp = ^{m_bresp[0], m_rresp[0]};

   assign busy      = (state_q != ENG_IDLE);
   assign m_awaddr  = addr_q;
   assign m_araddr  = addr_q;
   assign m_wdata   = wdata_q;
   assign m_awvalid = (state_q == ENG_WADDR) && !aw_done_q;
   assign m_wvalid  = (state_q == ENG_WADDR) && !w_done_q;
   assign m_bready  = (state_q == ENG_WRESP);
   assign m_arvalid = (state_q == ENG_RADDR);
   assign m_rready  = (state_q == ENG_RDATA);

   assign aw_hs  = m_awvalid && m_awready;
   assign w_hs   = m_wvalid && m_wready;
   assign ar_hs  = m_arvalid && m_arready;
   assign aw_all = aw_done_q || aw_hs;
   assign w_all  = w_done_q || w_hs;

   axbr_cnt #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start && !busy),
      .run     (busy),
      .expired (tmo_hit)
   );

   // a response in the final cycle wins over the timeout
   always_comb begin
      done   = 1'b0;
      result = RES_OK;
      unique case (state_q)
         ENG_WRESP: begin
            if (m_bvalid) begin
               done   = 1'b1;
               result = m_bresp[1] ? RES_ERR : RES_OK;
            end else if (tmo_hit) begin
               done   = 1'b1;
               result = RES_TMO;
            end
         end
         ENG_RDATA: begin
            if (m_rvalid) begin
               done   = 1'b1;
               result = m_rresp[1] ? RES_ERR : RES_OK;
            end else if (tmo_hit) begin
               done   = 1'b1;
               result = RES_TMO;
            end
         end
         ENG_WADDR, ENG_RADDR: begin
            if (tmo_hit) begin
               done   = 1'b1;
               result = RES_TMO;
            end
         end
         default: ;
      endcase
   end

   assign done_rd = rd_q;
   assign rdata   = m_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ENG_IDLE;
         aw_done_q <= 1'b0;
         w_done_q  <= 1'b0;
         rd_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
      end else begin
         unique case (state_q)
            ENG_IDLE: begin
               if (start) begin
                  state_q   <= start_rd ? ENG_RADDR : ENG_WADDR;
                  addr_q    <= start_addr;
                  wdata_q   <= start_wdata;
                  rd_q      <= start_rd;
                  aw_done_q <= 1'b0;
                  w_done_q  <= 1'b0;
               end
            end
            ENG_WADDR: begin
               if (done) state_q <= ENG_IDLE;
               else begin
                  aw_done_q <= aw_all;
                  w_done_q  <= w_all;
                  if (aw_all && w_all) state_q <= ENG_WRESP;
               end
            end
            ENG_RADDR: begin
               if (done)       state_q <= ENG_IDLE;
               else if (ar_hs) state_q <= ENG_RDATA;
            end
            default: begin
               if (done) state_q <= ENG_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/axbr_regs.sv
module axbr_regs
   import axbr_pkg::*;
#(
   parameter int unsigned RW       = 16,
   parameter int unsigned INIT_CYC = 16,
   parameter int unsigned AW       = 2 * RW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [RW-1:0]     reg_wdata,
   output logic [RW-1:0]     reg_rdata,
   input  logic              ext_irq,
   output logic              irq,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic              eng_done_rd,
   input  result_e           eng_result,
   input  logic [AW-1:0]     eng_rdata,
   output logic              start,
   output logic              start_rd,
   output logic [AW-1:0]     xfer_addr,
   output logic [AW-1:0]     xfer_wdata,
   output logic [RW-1:0]     status_word,
   output logic [EV_N-1:0]   ctrl_en
);
   localparam logic [AW-1:0] STEP = AW'(AW / 8);

   logic [AW-1:0]   addr_q, wdata_q, rdat_q;
   logic [EV_N-1:0] ev_q, en_q, ev_set, ev_clr;
   logic            adv_q, avail_q, ready;
   logic            ctrl_wr, ok_done, rd_ok;
   logic [RW-1:0]   ctrl_word;
   logic            unused_wd;

   assign unused_wd = ^{reg_wdata[EV_LSB-1:4]};

   axbr_cnt #(.LIMIT(INIT_CYC)) u_init (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (1'b0),
      .run     (1'b1),
      .expired (ready)
   );

   assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
   assign start    = ctrl_wr && !eng_busy && is_xfer_cmd(reg_wdata[3:0]);
   assign start_rd = reg_wdata[1];
   assign ok_done  = eng_done && (eng_result == RES_OK);
   assign rd_ok    = ok_done && eng_done_rd;

   always_comb begin
      ev_set          = '0;
      ev_set[EVI_RD]  = rd_ok;
      ev_set[EVI_WR]  = ok_done && !eng_done_rd;
      ev_set[EVI_TMO] = eng_done && (eng_result == RES_TMO);
      ev_set[EVI_ERR] = eng_done && (eng_result == RES_ERR);
      ev_set[EVI_EXT] = ext_irq;
      ev_clr = (reg_wr && reg_addr == OFS_STATUS) ? reg_wdata[EV_LSB +: EV_N] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdat_q  <= '0;
         ev_q    <= '0;
         en_q    <= '0;
         adv_q   <= 1'b0;
         avail_q <= 1'b0;
      end else begin
         if (ok_done && adv_q) addr_q <= addr_q + STEP;
         if (reg_wr) begin
            unique case (reg_addr)
               OFS_CTRL:    en_q              <= reg_wdata[EV_LSB +: EV_N];
               OFS_ADDR_LO: addr_q[RW-1:0]    <= reg_wdata;
               OFS_ADDR_HI: addr_q[AW-1:RW]   <= reg_wdata;
               OFS_WDAT_LO: wdata_q[RW-1:0]   <= reg_wdata;
               OFS_WDAT_HI: wdata_q[AW-1:RW]  <= reg_wdata;
               default: ;
            endcase
         end
         if (start) adv_q <= reg_wdata[0];
         ev_q <= (ev_q & ~ev_clr) | ev_set;
         if (rd_ok) begin
            rdat_q  <= eng_rdata;
            avail_q <= 1'b1;
         end else if (reg_rd && reg_addr == OFS_RDAT_HI) begin
            avail_q <= 1'b0;
         end
      end
   end

   assign xfer_addr  = addr_q;
   assign xfer_wdata = wdata_q;
   assign ctrl_en    = en_q;
   assign irq        = |(ev_q & en_q);

   always_comb begin
      status_word                     = '0;
      status_word[EV_LSB +: EV_N]     = ev_q;
      status_word[ST_RDAVAIL]         = avail_q;
      status_word[ST_BUSY]            = eng_busy;
      status_word[ST_READY]           = ready;
      ctrl_word                       = '0;
      ctrl_word[EV_LSB +: EV_N]       = en_q;
   end

   always_comb begin
      unique case (reg_addr)
         OFS_STATUS:  reg_rdata = status_word;
         OFS_CTRL:    reg_rdata = ctrl_word;
         OFS_ADDR_LO: reg_rdata = addr_q[RW-1:0];
         OFS_ADDR_HI: reg_rdata = addr_q[AW-1:RW];
         OFS_WDAT_LO: reg_rdata = wdata_q[RW-1:0];
         OFS_WDAT_HI: reg_rdata = wdata_q[AW-1:RW];
         OFS_RDAT_LO: reg_rdata = rdat_q[RW-1:0];
         default:     reg_rdata = rdat_q[AW-1:RW];
      endcase
   end
endmodule

// File: rtl/axbr_host_bridge.sv
module axbr_host_bridge
   import axbr_pkg::*;
#(
   parameter int unsigned REG_W       = 16,
   parameter int unsigned TIMEOUT_CYC = 1024,
   parameter int unsigned INIT_CYC    = 16,
   localparam int unsigned AW         = 2 * REG_W,
   localparam int unsigned SW         = AW / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              ext_irq,
   output logic              irq,
   output logic [AW-1:0]     m_awaddr,
   output logic [2:0]        m_awprot,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [AW-1:0]     m_wdata,
   output logic [SW-1:0]     m_wstrb,
   output logic              m_wvalid,
   input  logic              m_wready,
   input  logic [1:0]        m_bresp,
   input  logic              m_bvalid,
   output logic              m_bready,
   output logic [AW-1:0]     m_araddr,
   output logic [2:0]        m_arprot,
   output logic              m_arvalid,
   input  logic              m_arready,
   input  logic [AW-1:0]     m_rdata,
   input  logic [1:0]        m_rresp,
   input  logic              m_rvalid,
   output logic              m_rready
);
   if (REG_W != 16) begin : g_bad_regw
      $error("axbr_host_bridge: REG_W must be 16 (status layout)");
   end
   if (TIMEOUT_CYC < 4) begin : g_bad_tmo
      $error("axbr_host_bridge: TIMEOUT_CYC must be at least 4");
   end
   if (INIT_CYC < 1) begin : g_bad_init
      $error("axbr_host_bridge: INIT_CYC must be at least 1");
   end

   logic            eng_busy, eng_done, eng_done_rd, start, start_rd;
   result_e         eng_result;
   logic [AW-1:0]   eng_rdata, xfer_addr, xfer_wdata;
   logic [REG_W-1:0] status_word;
   logic [EV_N-1:0] ctrl_en;

   assign m_awprot = 3'b000;
   assign m_arprot = 3'b000;
   assign m_wstrb  = '1;

   axbr_regs #(.RW(REG_W), .INIT_CYC(INIT_CYC), .AW(AW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_addr    (reg_addr),
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .ext_irq     (ext_irq),
      .irq         (irq),
      .eng_busy    (eng_busy),
      .eng_done    (eng_done),
      .eng_done_rd (eng_done_rd),
      .eng_result  (eng_result),
      .eng_rdata   (eng_rdata),
      .start       (start),
      .start_rd    (start_rd),
      .xfer_addr   (xfer_addr),
      .xfer_wdata  (xfer_wdata),
      .status_word (status_word),
      .ctrl_en     (ctrl_en)
   );

   axbr_engine #(.AW(AW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_rd    (start_rd),
      .start_addr  (xfer_addr),
      .start_wdata (xfer_wdata),
      .busy        (eng_busy),
      .done        (eng_done),
      .done_rd     (eng_done_rd),
      .result      (eng_result),
      .rdata       (eng_rdata),
      .m_awaddr    (m_awaddr),
      .m_awvalid   (m_awvalid),
      .m_awready   (m_awready),
      .m_wdata     (m_wdata),
      .m_wvalid    (m_wvalid),
      .m_wready    (m_wready),
      .m_bresp     (m_bresp),
      .m_bvalid    (m_bvalid),
      .m_bready    (m_bready),
      .m_araddr    (m_araddr),
      .m_arvalid   (m_arvalid),
      .m_arready   (m_arready),
      .m_rdata     (m_rdata),
      .m_rresp     (m_rresp),
      .m_rvalid    (m_rvalid),
      .m_rready    (m_rready)
   );
endmodule

// File: rtl/axbr_checker.sv
module axbr_checker #(
   parameter int unsigned AW          = 32,
   parameter int unsigned RW          = 16,
   parameter int unsigned TIMEOUT_CYC = 1024
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] m_awaddr,
   input logic          m_awvalid,
   input logic          m_awready,
   input logic          m_wvalid,
   input logic          m_bready,
   input logic [AW-1:0] m_araddr,
   input logic          m_arvalid,
   input logic          m_arready,
   input logic [1:0]    m_rresp,
   input logic          m_rvalid,
   input logic          m_rready,
   input logic          irq,
   input logic [RW-1:0] status_word,
   input logic [4:0]    ctrl_en
);
   int unsigned busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n)              busy_run <= 0;
      else if (status_word[6]) busy_run <= busy_run + 1;
      else                     busy_run <= 0;
   end

   // R8: any AXI request or response-ready implies busy
   a_r8_bus_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid || m_wvalid || m_arvalid || m_bready || m_rready) |-> status_word[6]);

   // R3: a waiting write address holds its value
   a_r3_aw_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !m_awready) |=> $stable(m_awaddr));

   // R3: a waiting read address holds its value
   a_r3_ar_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready) |=> $stable(m_araddr));

   // R7: no busy period outlasts the timeout window
   a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= TIMEOUT_CYC + 1);

   // R6: an error read response never raises read-done
   a_r6_err_no_rd_done: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rvalid && m_rready && m_rresp[1]) |=> !$rose(status_word[15]));

   // R5: read-done only follows an R handshake
   a_r5_rd_done_after_r: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_word[15]) |-> $past(m_rvalid && m_rready));

   // R2: ready never falls after it has risen
   a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(status_word[5]));

   // R12: irq needs at least one enable
   a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl_en != 5'd0));
endmodule

bind axbr_host_bridge axbr_checker #(
   .AW(AW), .RW(REG_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .m_awaddr    (m_awaddr),
   .m_awvalid   (m_awvalid),
   .m_awready   (m_awready),
   .m_wvalid    (m_wvalid),
   .m_bready    (m_bready),
   .m_araddr    (m_araddr),
   .m_arvalid   (m_arvalid),
   .m_arready   (m_arready),
   .m_rresp     (m_rresp),
   .m_rvalid    (m_rvalid),
   .m_rready    (m_rready),
   .irq         (irq),
   .status_word (status_word),
   .ctrl_en     (ctrl_en)
);

// File: tb/tb_axbr_host_bridge.sv
`timescale 1ns/1ps
module tb_axbr_host_bridge;
   localparam int unsigned TMO  = 64;
   localparam int unsigned INIT = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ext_irq = 1'b0;
   logic        irq;
   logic [31:0] m_awaddr, m_wdata, m_araddr;
   logic [2:0]  m_awprot, m_arprot;
   logic [3:0]  m_wstrb;
   logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
   logic        awready, wready, arready, bvalid, rvalid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;

   always #2 clk = ~clk;

   axbr_host_bridge #(.TIMEOUT_CYC(TMO), .INIT_CYC(INIT)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq(ext_irq), .irq(irq),
      .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(wready),
      .m_bresp(bresp), .m_bvalid(bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(arready),
      .m_rdata(rdata), .m_rresp(rresp), .m_rvalid(rvalid), .m_rready(m_rready)
   );

   int unsigned n_chk = 0, n_fail = 0;

   function automatic logic [31:0] rd_pat(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- AXI slave model ----------------
   logic        sl_hang = 1'b0;
   logic [1:0]  sl_resp = 2'b00;
   logic        aw_got, w_got, ar_got;
   logic [31:0] cap_awaddr, cap_wdata, cap_araddr;
   logic [3:0]  cap_wstrb;
   int unsigned n_aw, n_ar;

   always @(posedge clk) begin
      if (!rst_n) begin
         awready <= 0; wready <= 0; arready <= 0; bvalid <= 0; rvalid <= 0;
         bresp <= 0; rresp <= 0; rdata <= 0;
         aw_got <= 0; w_got <= 0; ar_got <= 0;
         cap_awaddr <= 0; cap_wdata <= 0; cap_araddr <= 0; cap_wstrb <= 0;
         n_aw <= 0; n_ar <= 0;
      end else begin
         awready <= !sl_hang && ($urandom % 3 != 0);
         wready  <= !sl_hang && ($urandom % 3 != 0);
         arready <= !sl_hang && ($urandom % 3 != 0);
         if (m_awvalid && awready) begin
            cap_awaddr <= m_awaddr; aw_got <= 1; n_aw <= n_aw + 1;
         end
         if (m_wvalid && wready) begin
            cap_wdata <= m_wdata; cap_wstrb <= m_wstrb; w_got <= 1;
         end
         if (bvalid && m_bready) bvalid <= 0;
         else if (aw_got && w_got && !bvalid && ($urandom % 2 == 0)) begin
            bvalid <= 1; bresp <= sl_resp; aw_got <= 0; w_got <= 0;
         end
         if (m_arvalid && arready) begin
            cap_araddr <= m_araddr; ar_got <= 1; n_ar <= n_ar + 1;
         end
         if (rvalid && m_rready) rvalid <= 0;
         else if (ar_got && !rvalid && ($urandom % 2 == 0)) begin
            rvalid <= 1; rresp <= sl_resp; rdata <= rd_pat(cap_araddr); ar_got <= 0;
         end
      end
   end

   // ---------------- host access tasks ----------------
   task automatic hwr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      logic [15:0] s;
      int k;
      k = 0;
      do begin
         hrd(3'd0, s);
         k++;
      end while (s[6] && k < 400);
      chk({tag, " busy cleared"}, {31'd0, s[6]}, 32'd0);
   endtask

   logic [31:0] exp_rdat = 32'd0;

   task automatic run_xfer(input logic [3:0] cmd, input logic [31:0] a, input logic [31:0] d,
                           input logic hang, input logic [1:0] resp);
      logic [15:0] s, lo, hi;
      logic        is_rd, ok;
      logic [15:0] ev;
      logic [31:0] exp_a;
      int unsigned aw0, ar0;
      is_rd = cmd[1];
      ok    = !hang && !resp[1];
      sl_hang = hang; sl_resp = resp;
      hwr(3'd2, a[15:0]);  hwr(3'd3, a[31:16]);
      hwr(3'd4, d[15:0]);  hwr(3'd5, d[31:16]);
      hwr(3'd0, 16'hF800);
      aw0 = n_aw; ar0 = n_ar;
      hwr(3'd1, {12'd0, cmd});
      wait_idle("R8");
      if (ok)        ev = is_rd ? 16'h8000 : 16'h4000;
      else if (hang) ev = 16'h2000;
      else           ev = 16'h1000;
      if (ok && is_rd) exp_rdat = rd_pat(a);
      exp_a = (ok && cmd[0]) ? a + 32'd4 : a;
      hrd(3'd0, s);
      chk(ok ? "R5 event" : (hang ? "R7 event" : "R6 event"),
          {16'd0, s & 16'hF8E0}, {16'd0, ev | (ok && is_rd ? 16'h0080 : 16'h0) | 16'h0020});
      hrd(3'd2, lo); hrd(3'd3, hi);
      chk(ok ? "R5 address advance" : "R6/R7 address kept", {hi, lo}, exp_a);
      hrd(3'd6, lo); hrd(3'd7, hi);
      chk("R9 read data regs", {hi, lo}, exp_rdat);
      hrd(3'd0, s);
      chk("R9 avail cleared", {31'd0, s[7]}, 32'd0);
      if (is_rd) begin
         chk("R3 one AR handshake", n_ar - ar0, hang ? 0 : 1);
         chk("R4 read starts no AW", n_aw - aw0, 0);
         if (!hang) chk("R3 AR address", cap_araddr, a);
      end else begin
         chk("R3 one AW handshake", n_aw - aw0, hang ? 0 : 1);
         chk("R4 write starts no AR", n_ar - ar0, 0);
         if (!hang) begin
            chk("R3 AW address", cap_awaddr, a);
            chk("R3 W data", cap_wdata, d);
            chk("R3 W strobes", {28'd0, cap_wstrb}, 32'hF);
         end
      end
      sl_hang = 1'b0; sl_resp = 2'b00;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [15:0] s, v;
      logic [3:0]  codes [4];
      codes[0] = 4'h8; codes[1] = 4'h9; codes[2] = 4'hA; codes[3] = 4'hB;
      void'($urandom(32'd20240611));

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1 status in reset", {16'd0, reg_rdata}, 32'd0);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      chk("R1 no AXI activity", {27'd0, m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 32'd0);
      rst_n = 1'b1;

      // R2: ready after INIT cycles
      repeat (INIT - 3) @(posedge clk);
      hrd(3'd0, s);
      chk("R2 ready low early", {31'd0, s[5]}, 32'd0);
      repeat (5) @(posedge clk);
      hrd(3'd0, s);
      chk("R2 ready high", {31'd0, s[5]}, 32'd1);

      // R4: codes that start nothing
      for (int i = 0; i < 6; i++) begin
         logic [3:0] c;
         c = (i == 0) ? 4'h0 : (i == 1) ? 4'h5 : (i == 2) ? 4'hC : (i == 3) ? 4'hF : (i == 4) ? 4'h1 : 4'h7;
         hwr(3'd1, {12'd0, c});
         @(negedge clk);
         chk("R4 no-op code idle bus", {29'd0, m_awvalid, m_arvalid, m_wvalid}, 32'd0);
         hrd(3'd0, s);
         chk("R4 no-op code not busy", {31'd0, s[6]}, 32'd0);
      end

      // directed: write, read, read with advance
      run_xfer(4'h8, 32'h1234_5678, 32'hDEAD_BEEF, 1'b0, 2'b00);
      run_xfer(4'hA, 32'h0000_0100, 32'h0, 1'b0, 2'b01);
      run_xfer(4'hB, 32'hFFFF_FFFC, 32'h0, 1'b0, 2'b00);
      // R6: failed read keeps previous data
      run_xfer(4'hA, 32'h0000_0200, 32'h0, 1'b0, 2'b00);
      run_xfer(4'hB, 32'h0000_0300, 32'h0, 1'b0, 2'b10);
      run_xfer(4'h9, 32'h0000_0400, 32'h1, 1'b0, 2'b11);

      // random mix
      for (int i = 0; i < 30; i++) begin
         logic [3:0]  c;
         logic [31:0] a, d;
         logic        hg;
         logic [1:0]  rs;
         c  = codes[$urandom % 4];
         a  = {$urandom} & 32'hFFFF_FFFC;
         d  = $urandom;
         hg = ($urandom % 10 == 0);
         rs = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'b00;
         run_xfer(c, a, d, hg, rs);
      end

      // R7 / R8: stalled read, command while busy, timeout window
      sl_hang = 1'b1;
      hwr(3'd2, 16'h0040); hwr(3'd3, 16'h0000);
      hwr(3'd0, 16'hF800);
      hwr(3'd1, 16'h000B);
      hwr(3'd1, 16'h0008);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R8 command while busy ignored", {30'd0, m_awvalid, m_arvalid}, 32'd1);
      end
      repeat (TMO - 6) @(posedge clk);
      hrd(3'd0, s);
      chk("R7 still waiting before window", {16'd0, s & 16'h2040}, 32'h0040);
      wait_idle("R7");
      hrd(3'd0, s);
      chk("R7 timeout event only", {16'd0, s & 16'hF800}, 32'h2000);
      hrd(3'd2, v);
      chk("R7 address not advanced", {16'd0, v}, 32'h0040);
      sl_hang = 1'b0;

      // R11 / R10: external event and write-one-to-clear
      run_xfer(4'h8, 32'h0000_0010, 32'h0000_0001, 1'b0, 2'b00); // leaves bit14 set
      @(negedge clk); ext_irq = 1'b1;
      @(negedge clk); @(negedge clk); ext_irq = 1'b0;
      hrd(3'd0, s);
      chk("R11 ext event set", {16'd0, s & 16'hF800}, 32'h4800);
      hwr(3'd0, 16'h0000);
      hrd(3'd0, s);
      chk("R10 zero write keeps events", {16'd0, s & 16'hF800}, 32'h4800);
      hwr(3'd0, 16'h0800);
      hrd(3'd0, s);
      chk("R10 clears only written one", {16'd0, s & 16'hF800}, 32'h4000);

      // R12: enables and irq
      @(negedge clk);
      chk("R12 irq masked", {31'd0, irq}, 32'd0);
      hwr(3'd1, 16'h4000);
      @(negedge clk);
      chk("R12 irq with enable", {31'd0, irq}, 32'd1);
      hrd(3'd1, v);
      chk("R12 enable readback", {16'd0, v}, 32'h4000);
      hwr(3'd1, 16'h8000);
      @(negedge clk);
      chk("R12 other enable no irq", {31'd0, irq}, 32'd0);
      hwr(3'd1, 16'h4000);
      hwr(3'd0, 16'h4000);
      @(negedge clk);
      chk("R12 irq drops after clear", {31'd0, irq}, 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule